// File: doc/BRIEF.md
# Switchable-Domain Power Sequencer with Register Retention

This block lives in the always-on part of a chip and steers a switchable logic domain into and out of its unpowered state. On a sleep request it first copies a programmable number of domain registers, one word per cycle, into a retention memory that stays powered. It then walks the domain down through a fixed chain of steps: stop the domain clock, clamp its outputs with isolation, hold it in reset, and open the power switch. Waking reverses the chain, and the saved words are written back into the domain before its clock restarts. Each step is followed by a programmable number of settling cycles.

While the domain is dark, a sleep timer counts strobes from a slow tick so that protocol timing is kept. Either the timer reaching zero or an external wake event brings the domain back. A wake event that arrives while the domain is still going down is remembered and acted on as soon as the down sequence finishes. A sleep request whose programmed duration is below a minimum is refused, because a very short sleep costs more than it saves. For prototyping without real power switches, the domain reset is held for the whole time the power-off control is asserted, so register loss is reproduced.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, dom_clk_en is 1, dom_iso_en, dom_rst, dom_pwr_off, busy and sleep_refused are 0.
- R2: A sleep_req while busy is 0 with timer_load_val below MIN_SLEEP (default 8) sets sleep_refused on the next cycle and starts nothing; a value equal to MIN_SLEEP is accepted and an accepted request clears sleep_refused.
- R3: On an accepted request the block asserts dom_rd_en on consecutive cycles with dom_addr counting 0 to N-1, where N is xfer_words sampled at the request and limited to DEPTH (16); the word on dom_rd_data one cycle after each read is stored; N = 0 performs no reads.
- R4: After the save, dom_clk_en falls, then dom_iso_en rises, then dom_rst rises, then dom_pwr_off rises, each change step_wait+1 cycles after the previous one.
- R5: dom_rst is high whenever dom_pwr_off is high, and both fall in the same cycle when waking starts.
- R6: The sleep timer is loaded with timer_load_val at acceptance and drops by one per sleep_tick pulse; the domain stays off before it reaches zero and power-up starts when it does.
- R7: A wake_evt pulse while the domain is off starts power-up; a wake_evt while busy is 0 has no effect.
- R8: A wake_evt during the down sequence is latched: with no further input, dom_pwr_off stays high for exactly step_wait+2 cycles and the sequence returns to idle.
- R9: Power-up order: dom_pwr_off and dom_rst fall, the N saved words are written back with dom_wr_en at addresses 0 to N-1, then dom_clk_en rises, dom_iso_en falls step_wait+1 cycles later, and busy falls step_wait+1 cycles after that.
- R10: No word is read from or captured off the domain while dom_iso_en is high; values on dom_rd_data during isolation never reach the restored registers.
- R11: sleep_req is ignored while busy is 1: no second save is made and no new sleep follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle request to power the domain down |
| wake_evt | input | 1 | One-cycle external wake event |
| sleep_tick | input | 1 | Slow-clock strobe that decrements the sleep timer |
| timer_load_val | input | TW (16) | Sleep duration in ticks, loaded on acceptance |
| step_wait | input | SWW (4) | Settling cycles after each sequencing step, minus one |
| xfer_words | input | AW+1 (5) | Number of registers to save and restore |
| dom_addr | output | AW (4) | Register address toward the domain |
| dom_rd_en | output | 1 | Read strobe for saving a domain register |
| dom_rd_data | input | DW (16) | Register value returned one cycle after dom_rd_en |
| dom_wr_en | output | 1 | Write strobe for restoring a domain register |
| dom_wr_data | output | DW (16) | Value written back during restore |
| dom_clk_en | output | 1 | Domain clock enable |
| dom_iso_en | output | 1 | Domain output isolation clamp |
| dom_rst | output | 1 | Domain reset, held during emulated power loss |
| dom_pwr_off | output | 1 | Power switch control, 1 = domain unpowered |
| busy | output | 1 | Sequencer is not idle |
| sleep_refused | output | 1 | Last sleep request was refused as too short |

## Verification
The hardest situation to reach from the ports is a wake that lands in the middle of the down sequence, where it must be kept rather than lost or acted on early. The bench fires wake_evt a cycle after the request is accepted, while the save is still running, then stops all stimulus and measures how long dom_pwr_off stays high. It also proves that retention really carries the data: its domain model scrambles every register and the read-return bus while reset is held, so only words that went through the retention memory come back correct, and unsaved words stay scrambled.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_SAVE    = 4'd1,
    ST_SAVEW   = 4'd2,
    ST_GATE    = 4'd3,
    ST_ISO     = 4'd4,
    ST_RST     = 4'd5,
    ST_PWROFF  = 4'd6,
    ST_OFF     = 4'd7,
    ST_PWRON   = 4'd8,
    ST_RESTORE = 4'd9,
    ST_RESTW   = 4'd10,
    ST_UNGATE  = 4'd11,
    ST_UNISO   = 4'd12
  } psc_state_e;

  // Successor of each timed step in the chain.
  function automatic psc_state_e next_step(input psc_state_e s);
    case (s)
      ST_SAVEW:  next_step = ST_GATE;
      ST_GATE:   next_step = ST_ISO;
      ST_ISO:    next_step = ST_RST;
      ST_RST:    next_step = ST_PWROFF;
      ST_PWROFF: next_step = ST_OFF;
      ST_PWRON:  next_step = ST_RESTORE;
      ST_RESTW:  next_step = ST_UNGATE;
      ST_UNGATE: next_step = ST_UNISO;
      default:   next_step = ST_IDLE;
    endcase
  endfunction

  // States in which a wake event must be remembered.
  function automatic logic going_down(input psc_state_e s);
    going_down = (s == ST_SAVE) || (s == ST_SAVEW) || (s == ST_GATE) ||
                 (s == ST_ISO) || (s == ST_RST) || (s == ST_PWROFF);
  endfunction

endpackage

// File: rtl/psc_ret_ram.sv
module psc_ret_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port array with registered read, no reset.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/psc_sleep_timer.sv
module psc_sleep_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  input  logic          clr,
  output logic          zero
);

  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (clr) begin
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= 1'b1;
    end else if (tick && run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = run && (cnt == '0);

  // Without a tick, the remaining time never moves.
  assert_timer_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !load && !clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/psc_xfer_engine.sv
module psc_xfer_engine #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          restore,
  input  logic [AW:0]   count,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [AW-1:0] ram_raddr,
  output logic [AW-1:0] dom_addr,
  output logic          dom_rd_en,
  output logic          dom_wr_en,
  output logic [DW-1:0] dom_wr_data,
  output logic          done
);

  logic          run;
  logic          dir_q;
  logic [AW-1:0] idx;
  logic [AW:0]   last;
  logic          p_vld;
  logic [AW-1:0] p_idx;
  logic          zdone;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      dir_q <= 1'b0;
      idx   <= '0;
      last  <= '0;
      p_vld <= 1'b0;
      p_idx <= '0;
      zdone <= 1'b0;
    end else begin
      zdone <= start && (count == '0);
      p_vld <= run;
      p_idx <= idx;
      if (start) begin
        run   <= (count != '0);
        idx   <= '0;
        last  <= count - 1'b1;
        dir_q <= restore;
      end else if (run) begin
        if ({1'b0, idx} == last) run <= 1'b0;
        idx <= idx + 1'b1;
      end
    end
  end

  // Issue stage: read the domain (save) or the retention array (restore).
  assign dom_rd_en   = run && !dir_q;
  assign ram_raddr   = idx;
  // Second stage: capture into retention (save) or write back (restore).
  assign ram_we      = p_vld && !dir_q;
  assign ram_waddr   = p_idx;
  assign dom_wr_en   = p_vld && dir_q;
  assign dom_wr_data = ram_rdata;
  assign dom_addr    = dir_q ? p_idx : idx;
  assign done        = (p_vld && !run) || zdone;

  assert_single_direction_R3: assert property (@(posedge clk) disable iff (rst)
    !(dom_rd_en && dom_wr_en));

  assert_capture_follows_read_R3: assert property (@(posedge clk) disable iff (rst)
    dom_rd_en |=> ram_we);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int TW        = 16,
  parameter int SWW       = 4,
  parameter int MIN_SLEEP = 8,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          wake_evt,
  input  logic          sleep_tick,
  input  logic [TW-1:0] timer_load_val,
  input  logic [SWW-1:0] step_wait,
  input  logic [AW:0]   xfer_words,
  output logic [AW-1:0] dom_addr,
  output logic          dom_rd_en,
  input  logic [DW-1:0] dom_rd_data,
  output logic          dom_wr_en,
  output logic [DW-1:0] dom_wr_data,
  output logic          dom_clk_en,
  output logic          dom_iso_en,
  output logic          dom_rst,
  output logic          dom_pwr_off,
  output logic          busy,
  output logic          sleep_refused
);

  localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);
  localparam logic [TW-1:0] MIN_W   = TW'(MIN_SLEEP);

  psc_state_e    st;
  logic [SWW-1:0] wcnt;
  logic [AW:0]   words_q;
  logic [AW:0]   words_lim;
  logic          wake_pend;
  logic          clk_en_q, iso_q, rst_q, off_q, refused_q;

  logic          accept, wait_done, wake_any, tmr_zero;
  logic          xfer_start, xfer_restore, xfer_done;
  logic [AW:0]   xfer_count;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_rdata;

  assign words_lim    = (xfer_words > DEPTH_W) ? DEPTH_W : xfer_words;
  assign accept       = (st == ST_IDLE) && sleep_req && (timer_load_val >= MIN_W);
  assign wait_done    = (wcnt == step_wait);
  assign wake_any     = wake_pend || wake_evt || tmr_zero;
  assign xfer_restore = (st == ST_PWRON);
  assign xfer_start   = accept || ((st == ST_PWRON) && wait_done);
  assign xfer_count   = (st == ST_IDLE) ? words_lim : words_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wcnt      <= '0;
      words_q   <= '0;
      wake_pend <= 1'b0;
      clk_en_q  <= 1'b1;
      iso_q     <= 1'b0;
      rst_q     <= 1'b0;
      off_q     <= 1'b0;
      refused_q <= 1'b0;
    end else begin
      if (going_down(st) && wake_evt) wake_pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (sleep_req) begin
            if (timer_load_val < MIN_W) begin
              refused_q <= 1'b1;
            end else begin
              refused_q <= 1'b0;
              words_q   <= words_lim;
              wake_pend <= 1'b0;
              st        <= ST_SAVE;
            end
          end
        end
        ST_SAVE: begin
          if (xfer_done) begin
            wcnt <= '0;
            st   <= ST_SAVEW;
          end
        end
        ST_RESTORE: begin
          if (xfer_done) begin
            wcnt <= '0;
            st   <= ST_RESTW;
          end
        end
        ST_OFF: begin
          if (wake_any) begin
            off_q     <= 1'b0;
            rst_q     <= 1'b0;
            wake_pend <= 1'b0;
            wcnt      <= '0;
            st        <= ST_PWRON;
          end
        end
        default: begin
          if (wait_done) begin
            wcnt <= '0;
            st   <= next_step(st);
            case (next_step(st))
              ST_GATE:   clk_en_q <= 1'b0;
              ST_ISO:    iso_q    <= 1'b1;
              ST_RST:    rst_q    <= 1'b1;
              ST_PWROFF: off_q    <= 1'b1;
              ST_UNGATE: clk_en_q <= 1'b1;
              ST_UNISO:  iso_q    <= 1'b0;
              default:   ;
            endcase
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
    end
  end

  psc_sleep_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (timer_load_val),
    .tick     (sleep_tick),
    .clr      ((st == ST_OFF) && wake_any),
    .zero     (tmr_zero)
  );

  psc_xfer_engine #(.DW(DW), .DEPTH(DEPTH)) u_xfer (
    .clk         (clk),
    .rst         (rst),
    .start       (xfer_start),
    .restore     (xfer_restore),
    .count       (xfer_count),
    .ram_rdata   (ram_rdata),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_raddr   (ram_raddr),
    .dom_addr    (dom_addr),
    .dom_rd_en   (dom_rd_en),
    .dom_wr_en   (dom_wr_en),
    .dom_wr_data (dom_wr_data),
    .done        (xfer_done)
  );

  psc_ret_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (dom_rd_data),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign dom_clk_en    = clk_en_q;
  assign dom_iso_en    = iso_q;
  assign dom_rst       = rst_q;
  assign dom_pwr_off   = off_q;
  assign busy          = (st != ST_IDLE);
  assign sleep_refused = refused_q;

  assert_refuse_short_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && sleep_req && (timer_load_val < MIN_W)) |=> (sleep_refused && !busy));

  assert_off_is_isolated_R4: assert property (@(posedge clk) disable iff (rst)
    dom_pwr_off |-> (dom_iso_en && !dom_clk_en));

  assert_iso_after_gate_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dom_iso_en) |-> !dom_clk_en);

  assert_reset_covers_off_R5: assert property (@(posedge clk) disable iff (rst)
    dom_pwr_off |-> dom_rst);

  assert_release_together_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(dom_pwr_off) |-> $fell(dom_rst));

  assert_ungate_first_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(dom_iso_en) |-> dom_clk_en);

  assert_restore_powered_R9: assert property (@(posedge clk) disable iff (rst)
    dom_wr_en |-> (!dom_pwr_off && !dom_rst && dom_iso_en));

  assert_no_capture_isolated_R10: assert property (@(posedge clk) disable iff (rst)
    (ram_we || dom_rd_en) |-> !dom_iso_en);

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

  localparam int DW = 16, DEPTH = 16, AW = 4, TW = 16, SWW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_req = 1'b0, wake_evt = 1'b0, sleep_tick = 1'b0;
  logic [TW-1:0] timer_load_val = '0;
  logic [SWW-1:0] step_wait = '0;
  logic [AW:0]   xfer_words = '0;
  logic [AW-1:0] dom_addr;
  logic          dom_rd_en, dom_wr_en;
  logic [DW-1:0] dom_rd_data, dom_wr_data;
  logic          dom_clk_en, dom_iso_en, dom_rst, dom_pwr_off, busy, sleep_refused;

  always #2 clk = ~clk;

  pwr_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .sleep_tick(sleep_tick), .timer_load_val(timer_load_val), .step_wait(step_wait),
    .xfer_words(xfer_words), .dom_addr(dom_addr), .dom_rd_en(dom_rd_en),
    .dom_rd_data(dom_rd_data), .dom_wr_en(dom_wr_en), .dom_wr_data(dom_wr_data),
    .dom_clk_en(dom_clk_en), .dom_iso_en(dom_iso_en), .dom_rst(dom_rst),
    .dom_pwr_off(dom_pwr_off), .busy(busy), .sleep_refused(sleep_refused)
  );

  // Switchable-domain register model: loses state while in reset.
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] rd_q;
  logic          preload = 1'b0;
  logic [DW-1:0] seed = '0;
  assign dom_rd_data = rd_q;

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < DEPTH; i++) model[i] <= seed + DW'(i);
    end else if (dom_rst) begin
      for (int i = 0; i < DEPTH; i++) model[i] <= 16'hDEAD ^ DW'(i);
      rd_q <= 16'hBAD0;
    end else begin
      if (dom_wr_en) model[dom_addr] <= dom_wr_data;
      if (dom_rd_en) rd_q <= model[dom_addr];
    end
  end

  int nchk = 0, nerr = 0;
  int n = 0;
  int t_gate, t_iso, t_rst, t_off, t_on, t_rrel, t_ungate, t_irel, t_idle;
  int rd_cnt, wr_cnt, addr_bad, off_hi;
  logic p_clk, p_iso, p_rst, p_off, p_busy;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_rec();
    t_gate = -1; t_iso = -1; t_rst = -1; t_off = -1; t_on = -1;
    t_rrel = -1; t_ungate = -1; t_irel = -1; t_idle = -1;
    rd_cnt = 0; wr_cnt = 0; addr_bad = 0; off_hi = 0;
  endtask

  // One cycle: advance to the falling edge, then observe the outputs.
  task automatic step();
    @(negedge clk);
    n++;
    if (p_clk && !dom_clk_en) t_gate = n;
    if (!p_iso && dom_iso_en) t_iso = n;
    if (!p_rst && dom_rst) t_rst = n;
    if (!p_off && dom_pwr_off) t_off = n;
    if (p_off && !dom_pwr_off) t_on = n;
    if (p_rst && !dom_rst) t_rrel = n;
    if (!p_clk && dom_clk_en) t_ungate = n;
    if (p_iso && !dom_iso_en) t_irel = n;
    if (p_busy && !busy) t_idle = n;
    if (dom_pwr_off) off_hi++;
    if (dom_rd_en) begin
      if (int'(dom_addr) != rd_cnt) addr_bad++;
      rd_cnt++;
    end
    if (dom_wr_en) begin
      if (int'(dom_addr) != wr_cnt) addr_bad++;
      wr_cnt++;
    end
    p_clk = dom_clk_en; p_iso = dom_iso_en; p_rst = dom_rst;
    p_off = dom_pwr_off; p_busy = busy;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 600 && busy; g++) step();
    check(!busy, "R9 sequence returns idle", busy, 0);
  endtask

  task automatic check_data(input int words, input logic [DW-1:0] s);
    for (int i = 0; i < DEPTH; i++) begin
      if (i < words)
        check(model[i] == s + DW'(i), "R10 restored word", model[i], s + DW'(i));
      else
        check(model[i] == (16'hDEAD ^ DW'(i)), "R3 unsaved word lost", model[i], 16'hDEAD ^ DW'(i));
    end
  endtask

  // Vector table: {words, step_wait, timer load, wake by timer}
  localparam logic [31:0] VEC [4] = '{
    {8'd4,  8'd0, 8'd8,  8'd1},
    {8'd20, 8'd2, 8'd12, 8'd0},
    {8'd1,  8'd3, 8'd9,  8'd1},
    {8'd0,  8'd1, 8'd30, 8'd0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int words, sw, ld, lim;
    bit by_tmr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    p_clk = dom_clk_en; p_iso = dom_iso_en; p_rst = dom_rst; p_off = dom_pwr_off; p_busy = busy;
    step();
    // R1: reset state
    check(dom_clk_en == 1'b1, "R1 clk_en after reset", dom_clk_en, 1);
    check(!dom_iso_en && !dom_rst && !dom_pwr_off, "R1 iso/rst/off after reset",
          {dom_iso_en, dom_rst, dom_pwr_off}, 0);
    check(!busy && !sleep_refused, "R1 busy/refused after reset", {busy, sleep_refused}, 0);

    // R2: too short a sleep is refused
    timer_load_val = 16'd7; xfer_words = 5'd3; step_wait = 4'd1;
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    check(sleep_refused == 1'b1, "R2 refused flag", sleep_refused, 1);
    for (int k = 0; k < 5; k++) step();
    check(!busy && dom_clk_en && !dom_iso_en, "R2 no sequence after refusal",
          {busy, dom_clk_en, dom_iso_en}, 2);

    // R7: wake event in idle has no effect
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    for (int k = 0; k < 4; k++) step();
    check(!busy && dom_clk_en && !dom_pwr_off, "R7 idle wake ignored",
          {busy, dom_clk_en, dom_pwr_off}, 2);

    // Table-driven full sleep/wake cycles
    for (int v = 0; v < 4; v++) begin
      words  = int'(VEC[v][31:24]);
      sw     = int'(VEC[v][23:16]);
      ld     = int'(VEC[v][15:8]);
      by_tmr = VEC[v][0];
      lim    = (words > DEPTH) ? DEPTH : words;
      xfer_words = 5'(words); step_wait = 4'(sw); timer_load_val = 16'(ld);
      seed = DW'(16'h1100 * (v + 1));
      preload = 1'b1; step(); preload = 1'b0; step();
      clear_rec();
      sleep_req = 1'b1; step(); sleep_req = 1'b0;
      check(busy == 1'b1, "R2 request at threshold or above accepted", busy, 1);
      check(sleep_refused == 1'b0, "R2 accepted request clears refused", sleep_refused, 0);
      for (int g = 0; g < 300 && !dom_pwr_off; g++) step();
      check(dom_pwr_off == 1'b1, "R4 reached power-off", dom_pwr_off, 1);
      check(rd_cnt == lim, "R3 words read", rd_cnt, lim);
      check(addr_bad == 0, "R3 read addresses consecutive", addr_bad, 0);
      check(t_iso - t_gate == sw + 1, "R4 gate to isolate", t_iso - t_gate, sw + 1);
      check(t_rst - t_iso == sw + 1, "R4 isolate to reset", t_rst - t_iso, sw + 1);
      check(t_off - t_rst == sw + 1, "R4 reset to power-off", t_off - t_rst, sw + 1);
      if (by_tmr) begin
        for (int k = 1; k <= ld; k++) begin
          sleep_tick = 1'b1; step(); sleep_tick = 1'b0; step(); step();
          if (k < ld) check(dom_pwr_off == 1'b1, "R6 still off before timer zero", dom_pwr_off, 1);
        end
        for (int g = 0; g < 4 && dom_pwr_off; g++) step();
        check(dom_pwr_off == 1'b0, "R6 timer zero wakes domain", dom_pwr_off, 0);
      end else begin
        for (int k = 0; k < 10; k++) step();
        check(dom_pwr_off == 1'b1, "R7 stays off without wake", dom_pwr_off, 1);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        for (int g = 0; g < 4 && dom_pwr_off; g++) step();
        check(dom_pwr_off == 1'b0, "R7 wake event powers up", dom_pwr_off, 0);
      end
      wait_idle();
      check(t_on == t_rrel, "R5 reset and power released together", t_rrel, t_on);
      check(t_ungate > t_on, "R9 clock after power", t_ungate, t_on + 1);
      check(wr_cnt == lim, "R9 words restored", wr_cnt, lim);
      check(addr_bad == 0, "R9 restore addresses consecutive", addr_bad, 0);
      check(t_irel - t_ungate == sw + 1, "R9 ungate to isolation release", t_irel - t_ungate, sw + 1);
      check(t_idle - t_irel == sw + 1, "R9 isolation release to idle", t_idle - t_irel, sw + 1);
      check_data(lim, seed);
    end

    // R8 + R11: wake during power-down is latched; sleep requests while busy ignored
    xfer_words = 5'd2; step_wait = 4'd1; timer_load_val = 16'd100;
    seed = 16'h7700;
    preload = 1'b1; step(); preload = 1'b0; step();
    clear_rec();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    step();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    for (int g = 0; g < 300 && t_on < 0; g++) step();
    check(off_hi == 3, "R8 pending wake off duration", off_hi, 3);
    check(rd_cnt == 2, "R11 no second save while busy", rd_cnt, 2);
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    wait_idle();
    for (int k = 0; k < 10; k++) step();
    check(!busy && dom_clk_en, "R11 request during power-up ignored", {busy, dom_clk_en}, 1);
    check(!sleep_refused, "R11 no refusal flag from ignored request", sleep_refused, 0);
    check_data(2, 16'h7700);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule